// File: doc/BRIEF.md
# Lock-Acquisition Sweep and Drift Tracker

This block produces the 8-bit code for a DAC whose output is summed into the coarse tuning of an oscillator. While the phase-locked loop is not locked, the code climbs by one on every slow tick and wraps from 255 to 0. This gives a repeating ramp that drags the oscillator frequency across the loop's capture range. When the lock input rises, the ramp stops and the code keeps the value it had when lock was found.

Once locked, the same counter follows slow thermal drift. A signed sample of the loop's correction effort is compared with an entry threshold and a lower release threshold. When the correction's magnitude passes the entry level, the block moves the code one step per tick in the direction that pulls the correction back toward zero. It keeps stepping until the magnitude falls under the release level. In this mode the code stops at 0 and at 255 instead of wrapping. If lock is lost, the ramp resumes from whatever code is current.

The tick comes from a prescaler on the system clock. The lock input is asynchronous and is retimed inside the block.

Top module: `lock_sweep_tracker`

## Requirements
- R1: After reset, sweepCode is 0.
- R2: With lock deasserted, sweepCode increases by exactly 1 per TICK_DIV clock cycles (one tick). It wraps from 255 to 0, so any window of k*TICK_DIV cycles adds k modulo 256.
- R3: While lock is deasserted, corrIn has no effect on the ramp rate or direction.
- R4: With lock asserted and not tracking, sweepCode holds its value across ticks.
- R5: With lock asserted, tracking starts only when corrIn (signed 8-bit two's complement, full scale ±127) is above +64 or below -64. The values +64 and -64 do not start it.
- R6: While tracking, each tick moves sweepCode up by 1 when corrIn is positive and down by 1 when corrIn is negative.
- R7: Tracking continues while |corrIn| is 48 or more. It stops once -48 < corrIn < +48, and the code then holds.
- R8: While tracking, sweepCode saturates at 255 going up and at 0 going down, and does not wrap.
- R9: When lock drops, the ramp restarts from the current sweepCode, not from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| lockIn | input | 1 | Asynchronous lock indication from the loop detector |
| corrIn | input | 8 | Signed sample of the loop correction effort |
| sweepCode | output | 8 | Code driving the tuning-offset DAC |

## Verification
The stepping function is driven by one sequence of lock and correction settings. In each setting, the code's change over a fixed number of tick periods shows which of four behaviours is active: wrapping ramp, hold, step up or step down. The sequence places correction values exactly on and one count past both thresholds, and on both signs. This separates an off-by-one threshold, a missing hysteresis band or an inverted step direction. It also applies a large correction while unlocked, which separates a block that ignores the correction during sweep from one that does not. Long tracking runs against both rails separate saturation from wrapping. A lock drop after tracking shows whether the ramp resumes from the held code or from zero.

// File: rtl/lst_pkg.sv
package lst_pkg;
  // Strobes from control to the code counter
  typedef struct packed {
    logic stepUp;
    logic stepDn;
    logic wrapOk;
  } stepCmd_t;
endpackage

// File: rtl/lst_control.sv
module lst_control
  import lst_pkg::*;
#(
  parameter int TICK_DIV = 195312,
  parameter int CORR_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lockIn,
  input  logic signed [CORR_W-1:0] corrIn,
  output stepCmd_t                 cmd
);
  localparam int DIV_W   = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int FULL    = 2 ** (CORR_W - 1) - 1;
  localparam int ENTER   = (FULL * 2 + 2) / 4;   // half of full scale
  localparam int RELEASE = (FULL * 3 + 4) / 8;   // enter level minus hysteresis
  localparam logic signed [CORR_W-1:0] ENTER_P = CORR_W'(ENTER);
  localparam logic signed [CORR_W-1:0] ENTER_N = -ENTER_P;
  localparam logic signed [CORR_W-1:0] REL_P   = CORR_W'(RELEASE);
  localparam logic signed [CORR_W-1:0] REL_N   = -REL_P;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [1:0]       syncQ;
  logic             lockSync;
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic             tracking;
  logic             outside;
  logic             inBand;
  logic             corrNeg;

  // Two-flop retiming of the asynchronous lock flag
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b00;
    else       syncQ <= {syncQ[0], lockIn};
  end
  assign lockSync = syncQ[1];

  // Tick prescaler
  always_ff @(posedge clk) begin
    if (!rstN)                 divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                       divCnt <= divCnt + 1'b1;
  end
  assign tick = (divCnt == DIV_LAST);

  // Threshold comparisons
  assign outside = (corrIn > ENTER_P) || (corrIn < ENTER_N);
  assign inBand  = (corrIn < REL_P) && (corrIn > REL_N);
  assign corrNeg = corrIn[CORR_W-1];

  // Tracking flag with hysteresis
  always_ff @(posedge clk) begin
    if (!rstN)                 tracking <= 1'b0;
    else if (!lockSync)        tracking <= 1'b0;
    else if (!tracking && outside) tracking <= 1'b1;
    else if (tracking && inBand)   tracking <= 1'b0;
  end

  always_comb begin
    cmd.wrapOk = !lockSync;
    cmd.stepUp = tick && (!lockSync || (tracking && !inBand && !corrNeg));
    cmd.stepDn = tick && lockSync && tracking && !inBand && corrNeg;
  end

  p_single_dir_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.stepUp, cmd.stepDn}));
  p_hold_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lockSync && !tracking) |-> !(cmd.stepUp || cmd.stepDn));
  p_enter_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lockSync && !tracking && (corrIn > ENTER_P)) |=> tracking);
  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tracking && inBand) |=> !tracking);
  p_tick_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp || cmd.stepDn) |-> tick);
endmodule

// File: rtl/lst_datapath.sv
module lst_datapath
  import lst_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCmd_t          cmd,
  output logic [CODE_W-1:0] code
);
  localparam int STAGES = CODE_W / NIB_W;
  localparam logic [NIB_W-1:0]  NIB_MAX  = '1;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [STAGES:0] onesBelow;
  logic [STAGES:0] zerosBelow;
  logic            allOnes;
  logic            allZeros;
  logic            upEn;
  logic            dnEn;

  assign onesBelow[0]  = 1'b1;
  assign zerosBelow[0] = 1'b1;
  assign allOnes  = onesBelow[STAGES];
  assign allZeros = zerosBelow[STAGES];
  assign upEn = cmd.stepUp && !(allOnes && !cmd.wrapOk);
  assign dnEn = cmd.stepDn && !(allZeros && !cmd.wrapOk);

  // Cascaded up/down nibble counters
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [NIB_W-1:0] nib;
    assign onesBelow[i+1]  = onesBelow[i]  && (nib == NIB_MAX);
    assign zerosBelow[i+1] = zerosBelow[i] && (nib == '0);
    assign code[i*NIB_W +: NIB_W] = nib;
    always_ff @(posedge clk) begin
      if (!rstN)                      nib <= '0;
      else if (upEn && onesBelow[i])  nib <= nib + 1'b1;
      else if (dnEn && zerosBelow[i]) nib <= nib - 1'b1;
    end
  end

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp && cmd.wrapOk && code == CODE_MAX) |=> (code == '0));
  p_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp && code != CODE_MAX) |=> (code == $past(code) + 1'b1));
  p_sat_top_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp && !cmd.wrapOk && code == CODE_MAX) |=> (code == CODE_MAX));
  p_sat_bot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepDn && !cmd.wrapOk && code == '0) |=> (code == '0));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.stepUp || cmd.stepDn) |=> $stable(code));
endmodule

// File: rtl/lock_sweep_tracker.sv
module lock_sweep_tracker
  import lst_pkg::*;
#(
  parameter int TICK_DIV = 195312,
  parameter int CODE_W   = 8,
  parameter int NIB_W    = 4,
  parameter int CORR_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lockIn,
  input  logic signed [CORR_W-1:0] corrIn,
  output logic [CODE_W-1:0]        sweepCode
);
  stepCmd_t cmd;

  lst_control #(.TICK_DIV(TICK_DIV), .CORR_W(CORR_W)) u_control (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .corrIn(corrIn), .cmd(cmd)
  );

  lst_datapath #(.CODE_W(CODE_W), .NIB_W(NIB_W)) u_datapath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .code(sweepCode)
  );
endmodule

// File: tb/lock_sweep_tracker_tb.sv
module lock_sweep_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int SW = 0, HO = 1, UP = 2, DN = 3;
  localparam int NV = 15;
  // {lock, corr, ticks, mode}
  localparam int VEC [NV][4] = '{
    '{0,    0, 20, SW}, '{0,  100, 20, SW}, '{1,    0, 10, HO},
    '{1,   64, 10, HO}, '{1,   65, 10, UP}, '{1,   48, 10, UP},
    '{1,   47, 10, HO}, '{1,   60, 10, HO}, '{1,  -64, 10, HO},
    '{1,  -65, 10, DN}, '{1,  -48, 10, DN}, '{1,  -47, 10, HO},
    '{1, -128, 10, DN}, '{1,  127, 10, UP}, '{0,  127, 20, SW}
  };

  logic clk = 0;
  logic rstN = 0;
  logic lockIn = 0;
  logic signed [7:0] corrIn = 0;
  logic [7:0] sweepCode;
  int compared = 0;
  int mismatched = 0;

  lock_sweep_tracker #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .corrIn(corrIn), .sweepCode(sweepCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int model(input int c0, input int k, input int mode);
    case (mode)
      SW: return (c0 + k) % 256;
      UP: return (c0 + k > 255) ? 255 : c0 + k;
      DN: return (c0 - k < 0) ? 0 : c0 - k;
      default: return c0;
    endcase
  endfunction

  function automatic string reqOf(input int mode, input int corr);
    case (mode)
      SW: return (corr != 0) ? "R3 corr ignored in sweep" : "R2 sweep ramp";
      HO: return "R4/R5/R7 hold";
      default: return "R5/R6/R7 track step";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int c0, h;
    waitN(3);
    check("R1 reset code", sweepCode, 0);
    rstN = 1;

    // Table of settings
    for (int i = 0; i < NV; i++) begin
      lockIn = VEC[i][0][0];
      corrIn = 8'(VEC[i][1]);
      waitN(DIV + 4);
      c0 = sweepCode;
      waitN(VEC[i][2] * DIV);
      check(reqOf(VEC[i][3], VEC[i][1]), sweepCode, model(c0, VEC[i][2], VEC[i][3]));
    end

    // R2: full wrap returns to the same code
    c0 = sweepCode;
    waitN(256 * DIV);
    check("R2 full wrap", sweepCode, c0);

    // R9: resume from held code after lock loss
    lockIn = 1; corrIn = 8'sd100;
    waitN(20 * DIV);
    corrIn = 0;
    waitN(DIV + 4);
    h = sweepCode;
    waitN(5 * DIV);
    check("R4 hold before lock loss", sweepCode, h);
    lockIn = 0;
    waitN(3 * DIV);
    c0 = (sweepCode - h) & 255;
    check("R9 resume from held code", int'(c0 >= 2 && c0 <= 3), 1);

    // R8: saturation at both rails
    lockIn = 1; corrIn = 8'sd100;
    waitN(300 * DIV);
    check("R8 saturate top", sweepCode, 255);
    waitN(5 * DIV);
    check("R8 stay at top", sweepCode, 255);
    corrIn = -8'sd100;
    waitN(300 * DIV);
    check("R8 saturate bottom", sweepCode, 0);
    waitN(5 * DIV);
    check("R8 stay at bottom", sweepCode, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule